// File: doc/BRIEF.md
# Wide-to-Narrow Memory Access Adapter

This block lets a client that thinks in 128-bit words use a storage array whose data path is only 32 bits wide, with one address per 32-bit word. Each accepted write is broken into four 32-bit beats that land on four consecutive word addresses. Each accepted read fetches four such beats and packs them back into one 128-bit result, which is presented with a one-cycle valid pulse.

The same storage can be reached through two address views, chosen per command by a mode input. In the word view, the command address counts 32-bit words, so packed transfers step by four and the two low bits are dropped. In the block view, the command address counts whole 128-bit groups, so packed transfers step by one and the address is multiplied by four. A block-view write may mark some of its four words as not valid; those words are still written, with zero filler, so every group stays whole. While a transfer is in flight the adapter reports busy and takes no new command.

Top module: `wide_narrow_adapter`

## Requirements
- R1: After reset, busy and rdValid are low.
- R2: A command is taken at a rising edge where cmdValid is high and busy is low; busy is then high for exactly four cycles. cmdValid while busy is high has no effect on the storage or on later results.
- R3: With blockMode low, the group base is cmdAddr with its two least significant bits forced to zero, so an unaligned word address aliases to the start of its group of four.
- R4: With blockMode high, the group base is four times cmdAddr, truncated to the word-address width (block n covers words 4n to 4n+3).
- R5: wrData[127:96] goes to word base, [95:64] to base+1, [63:32] to base+2 and [31:0] to base+3; a read packs the words back in the same order, so both views see the same storage.
- R6: For a read taken at edge T, rdValid is high for exactly the one cycle after edge T+5, and rdData carries the packed word in that cycle.
- R7: In a block-mode write, wrKeep bit j set to 0 writes zero to word base+j instead of the matching data slice; in word mode wrKeep is ignored and all four words are written from wrData.
- R8: cmdAddr, blockMode, cmdWrite, wrData and wrKeep are captured at acceptance; changes to them during busy do not alter the transfer in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| cmdValid | input | 1 | A command is offered this cycle |
| cmdWrite | input | 1 | 1 for write, 0 for read |
| blockMode | input | 1 | 1 selects block addressing, 0 selects word addressing |
| cmdAddr | input | ADDR_W (10) | Command address, meaning depends on blockMode |
| wrData | input | WIDE_W (128) | Write data, top slice to the lowest word |
| wrKeep | input | WIDE_W/NARROW_W (4) | Per-word valid bits for block-mode writes, bit j for word base+j |
| busy | output | 1 | A transfer is in progress, commands are not taken |
| rdValid | output | 1 | One-cycle pulse, rdData holds a read result |
| rdData | output | WIDE_W (128) | Packed read result |

## Verification
The hardest situation to reach from the ports is a command that changes while the adapter is already busy, because a well-behaved client would simply wait. The bench therefore starts a block-mode write and then, in the busy cycles, drives a different write with a new address, mode and data, dropping it before busy falls; a later read of both targets shows that neither the storage nor the in-flight transfer was disturbed. Aliasing of unaligned word addresses and truncation of out-of-range block addresses are reached by writing through one view and reading back through the other.

// File: rtl/adapter_pkg.sv
package adapter_pkg;

  // Strobes from the sequencer to the datapath, one set per cycle.
  typedef struct packed {
    logic load;      // capture command fields and group base
    logic wrBeat;    // write one narrow word, then step
    logic rdBeat;    // read one narrow word, then step
    logic gather;    // shift the word read last cycle into the result
    logic finish;    // this gather completes a wide word
  } ctrlStrobes_t;

endpackage

// File: rtl/adapter_wordmem.sv
module adapter_wordmem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
    end
    if (re) begin
      rdataQ <= store[addr];
    end
  end

  assign rdata = rdataQ;

endmodule

// File: rtl/adapter_ctrl.sv
module adapter_ctrl
  import adapter_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cmdValid,
  input  logic         cmdWrite,
  output logic         busy,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic [CNT_W-1:0] beatCnt;
  logic             busyQ;
  logic             isWrite;
  logic             gatherQ;
  logic             finishQ;
  logic             accept;
  logic             lastBeat;

  assign accept   = cmdValid && !busyQ;
  assign lastBeat = busyQ && (beatCnt == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      beatCnt <= '0;
      isWrite <= 1'b0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      beatCnt <= '0;
      isWrite <= cmdWrite;
    end else if (busyQ) begin
      beatCnt <= beatCnt + 1'b1;
      if (lastBeat) begin
        busyQ <= 1'b0;
      end
    end
  end

  // Memory reads return one cycle late; delay the gather strobes to match.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatherQ <= 1'b0;
      finishQ <= 1'b0;
    end else begin
      gatherQ <= busyQ && !isWrite;
      finishQ <= lastBeat && !isWrite;
    end
  end

  always_comb begin
    strobes        = '0;
    strobes.load   = accept;
    strobes.wrBeat = busyQ && isWrite;
    strobes.rdBeat = busyQ && !isWrite;
    strobes.gather = gatherQ;
    strobes.finish = finishQ;
  end

  assign busy = busyQ;

endmodule

// File: rtl/adapter_dpath.sv
module adapter_dpath
  import adapter_pkg::*;
#(
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strobes,
  input  logic                       blockMode,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic [WIDE_W-1:0]          wrData,
  input  logic [WIDE_W/NARROW_W-1:0] wrKeep,
  output logic                       rdValid,
  output logic [WIDE_W-1:0]          rdData
);

  localparam int BEATS     = WIDE_W / NARROW_W;
  localparam int LOG_BEATS = (BEATS > 1) ? $clog2(BEATS) : 0;

  logic [ADDR_W-1:0]   baseAddr;
  logic [ADDR_W-1:0]   wordAddr;
  logic [WIDE_W-1:0]   wrShift;
  logic [BEATS-1:0]    keepShift;
  logic [NARROW_W-1:0] memWdata;
  logic [NARROW_W-1:0] memRdata;
  logic [WIDE_W-1:0]   packed_q;
  logic                rdValidQ;

  // Group base: word view clears the low bits, block view scales up.
  generate
    if (LOG_BEATS == 0) begin : g_noAlign
      assign baseAddr = cmdAddr;
    end else begin : g_align
      logic [ADDR_W-1:0] wordBase;
      logic [ADDR_W-1:0] blockBase;
      assign wordBase  = {cmdAddr[ADDR_W-1:LOG_BEATS], {LOG_BEATS{1'b0}}};
      assign blockBase = cmdAddr << LOG_BEATS;
      assign baseAddr  = blockMode ? blockBase : wordBase;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.load) begin
      wordAddr  <= baseAddr;
      wrShift   <= wrData;
      keepShift <= blockMode ? wrKeep : {BEATS{1'b1}};
    end else if (strobes.wrBeat || strobes.rdBeat) begin
      wordAddr  <= wordAddr + 1'b1;
      wrShift   <= wrShift << NARROW_W;
      keepShift <= keepShift >> 1;
    end
  end

  // Top slice always heads for the current (lowest remaining) word.
  assign memWdata = keepShift[0] ? wrShift[WIDE_W-1 -: NARROW_W] : '0;

  adapter_wordmem #(
    .ADDR_W(ADDR_W),
    .DATA_W(NARROW_W)
  ) mem_i (
    .clk  (clk),
    .we   (strobes.wrBeat),
    .re   (strobes.rdBeat),
    .addr (wordAddr),
    .wdata(memWdata),
    .rdata(memRdata)
  );

  // First word read ends up in the top slice after all shifts.
  always_ff @(posedge clk) begin
    if (strobes.gather) begin
      packed_q <= {packed_q[WIDE_W-NARROW_W-1:0], memRdata};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= strobes.gather && strobes.finish;
    end
  end

  assign rdValid = rdValidQ;
  assign rdData  = packed_q;

endmodule

// File: rtl/wide_narrow_adapter.sv
module wide_narrow_adapter
  import adapter_pkg::*;
#(
  parameter int WIDE_W   = 128,
  parameter int NARROW_W = 32,
  parameter int ADDR_W   = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cmdValid,
  input  logic                       cmdWrite,
  input  logic                       blockMode,
  input  logic [ADDR_W-1:0]          cmdAddr,
  input  logic [WIDE_W-1:0]          wrData,
  input  logic [WIDE_W/NARROW_W-1:0] wrKeep,
  output logic                       busy,
  output logic                       rdValid,
  output logic [WIDE_W-1:0]          rdData
);

  localparam int BEATS = WIDE_W / NARROW_W;

  ctrlStrobes_t ctrlStr;

  adapter_ctrl #(
    .BEATS(BEATS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cmdValid(cmdValid),
    .cmdWrite(cmdWrite),
    .busy    (busy),
    .strobes (ctrlStr)
  );

  adapter_dpath #(
    .WIDE_W  (WIDE_W),
    .NARROW_W(NARROW_W),
    .ADDR_W  (ADDR_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (ctrlStr),
    .blockMode(blockMode),
    .cmdAddr  (cmdAddr),
    .wrData   (wrData),
    .wrKeep   (wrKeep),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

endmodule

// File: rtl/adapter_checker.sv
module adapter_checker #(
  parameter int BEATS = 4
) (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic busy,
  input logic rdValid,
  input logic memWe
);

  localparam int RUN_W = $clog2(BEATS + 2) + 1;

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyRun <= '0;
    end else if (busy) begin
      busyRun <= busyRun + 1'b1;
    end else begin
      busyRun <= '0;
    end
  end

  AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !busy |=> busy); // R2

  AST_BUSY_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyRun < RUN_W'(BEATS)); // R2

  AST_BUSY_FULL_RUN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == RUN_W'(BEATS)); // R2

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy); // R2

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6

  AST_RDVALID_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(busy, 2) && !$past(busy)); // R6

endmodule

bind wide_narrow_adapter adapter_checker #(
  .BEATS(WIDE_W / NARROW_W)
) checker_i (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .busy    (busy),
  .rdValid (rdValid),
  .memWe   (ctrlStr.wrBeat)
);

// File: tb/wide_narrow_adapter_tb_top.sv
module wide_narrow_adapter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int WORDS = 1 << AW;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdValid = 1'b0;
  logic         cmdWrite = 1'b0;
  logic         blockMode = 1'b0;
  logic [AW-1:0] cmdAddr = '0;
  logic [127:0] wrData = '0;
  logic [3:0]   wrKeep = '0;
  logic         busy;
  logic         rdValid;
  logic [127:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_narrow_adapter #(
    .WIDE_W(128), .NARROW_W(32), .ADDR_W(AW)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWrite(cmdWrite),
    .blockMode(blockMode), .cmdAddr(cmdAddr), .wrData(wrData), .wrKeep(wrKeep),
    .busy(busy), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, updated on every rising edge.
  logic [31:0]  mm [WORDS];
  int           mBusy = 0;
  int           mRd = 0;
  bit           mValid = 0;
  logic [127:0] mData = '0;
  logic [127:0] mPend = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mRd = 0; mValid = 0;
    end else begin
      bit idle;
      int base;
      mValid = 0;
      if (mRd > 0) begin
        mRd--;
        if (mRd == 0) begin mValid = 1; mData = mPend; end
      end
      idle = (mBusy == 0);
      if (mBusy > 0) mBusy--;
      if (idle && cmdValid) begin
        if (blockMode) base = (int'(cmdAddr) * 4) % WORDS;
        else           base = int'(cmdAddr) & ~3;
        mBusy = 4;
        if (cmdWrite) begin
          for (int j = 0; j < 4; j++) begin
            if (blockMode && !wrKeep[j]) mm[base+j] = 32'h0;
            else                         mm[base+j] = wrData[127-32*j -: 32];
          end
        end else begin
          mPend = {mm[base], mm[base+1], mm[base+2], mm[base+3]};
          mRd = 5;
        end
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(busy === (mBusy > 0), "R2 busy", {127'b0, busy}, {127'b0, (mBusy > 0)});
      chk(rdValid === mValid, "R6 rdValid", {127'b0, rdValid}, {127'b0, mValid});
      if (mValid) chk(rdData === mData, "R5 rdData vs model", rdData, mData);
    end
  end

  task automatic issue(input bit wr, input bit bm, input int addr,
                       input logic [127:0] d, input logic [3:0] keep);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmdValid = 1'b1; cmdWrite = wr; blockMode = bm;
    cmdAddr = AW'(addr); wrData = d; wrKeep = keep;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic readChk(input bit bm, input int addr, input logic [127:0] exp, input string tag);
    int n;
    issue(1'b0, bm, addr, '0, '0);
    n = 0;
    while (!rdValid && n < 20) begin @(negedge clk); n++; end
    chk(rdValid === 1'b1 && rdData === exp, tag, rdData, exp);
  endtask

  localparam logic [127:0] D0 = 128'h00000001_00000002_00000003_00000004;
  localparam logic [127:0] D1 = 128'h11111111_22222222_33333333_44444444;
  localparam logic [127:0] D2 = 128'hA0A0A0A0_B1B1B1B1_C2C2C2C2_D3D3D3D3;
  localparam logic [127:0] D3 = 128'hDEADBEEF_CAFEF00D_0BADC0DE_12345678;
  localparam logic [127:0] D4 = 128'h55AA55AA_66BB66BB_77CC77CC_88DD88DD;
  localparam logic [127:0] D5 = 128'hF1F1F1F1_E2E2E2E2_D3D3D3D3_C4C4C4C4;
  localparam logic [127:0] D6 = 128'h01020304_05060708_090A0B0C_0D0E0F10;
  localparam logic [127:0] D7 = 128'h77777777_88888888_99999999_AAAAAAAA;
  localparam logic [127:0] D8 = 128'h13579BDF_2468ACE0_FEDCBA98_76543210;

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", {127'b0, busy}, '0);
    chk(rdValid === 1'b0, "R1 rdValid after reset", {127'b0, rdValid}, '0);

    // R5: word-view writes, block-view reads of the same storage
    issue(1'b1, 1'b0, 0, D0, 4'h0);
    issue(1'b1, 1'b0, 4, D1, 4'h0);
    readChk(1'b1, 0, D0, "R5 block 0 after word 0 write");
    readChk(1'b1, 1, D1, "R5 block 1 after word 4 write");
    readChk(1'b0, 4, D1, "R5 word 4 readback");

    // R3: unaligned word address aliases to its group start
    issue(1'b1, 1'b0, 9, D2, 4'h0);
    readChk(1'b0, 8, D2, "R3 word 9 aliases to 8");
    readChk(1'b1, 2, D2, "R3 block 2 sees aliased write");
    issue(1'b1, 1'b1, 3, D3, 4'hF);
    readChk(1'b0, 14, D3, "R3 word 14 read aliases to 12");

    // R4: block address scaled and truncated
    issue(1'b1, 1'b1, 261, D4, 4'hF);
    readChk(1'b1, 5, D4, "R4 block 261 wraps to block 5");
    readChk(1'b0, 20, D4, "R4 block 5 is word 20");

    // R7: partial keep in block mode, keep ignored in word mode
    issue(1'b1, 1'b1, 6, D5, 4'b0101);
    readChk(1'b1, 6, {D5[127:96], 32'h0, D5[63:32], 32'h0}, "R7 block keep 0101 zero fill");
    issue(1'b1, 1'b0, 28, D6, 4'b0000);
    readChk(1'b0, 28, D6, "R7 word mode ignores keep");

    // R2 / R8: commands and field changes while busy
    issue(1'b1, 1'b0, 40, D7, 4'h0);
    issue(1'b1, 1'b1, 11, D8, 4'hF);
    cmdValid = 1'b1; cmdWrite = 1'b1; blockMode = 1'b0;
    cmdAddr = AW'(40); wrData = ~D8; wrKeep = 4'h0;
    @(negedge clk);
    cmdAddr = AW'(44);
    @(negedge clk);
    cmdValid = 1'b0;
    readChk(1'b1, 11, D8, "R8 in-flight write unchanged");
    readChk(1'b0, 40, D7, "R2 command during busy ignored");

    // R6: back-to-back reads held on cmdValid
    @(negedge clk);
    while (busy) @(negedge clk);
    cmdValid = 1'b1; cmdWrite = 1'b0; blockMode = 1'b1;
    for (int k = 0; k < 30; k++) begin
      cmdAddr = AW'(k % 7);
      @(negedge clk);
    end
    cmdValid = 1'b0;
    repeat (10) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule